// File: doc/BRIEF.md
# Host-to-CPU Byte Exchange Port

This block lets an external host move bytes to and from an internal CPU through three active-low control pins (select, write strobe, read strobe) and an 8-bit data bus. A host write drops a byte into an inbound holding register. A host read collects a byte that the CPU left in an outbound holding register. A control/status register carries the handshake: an inbound-full flag, an outbound-full flag, a sticky overrun flag, a mode bit and three pin-direction bits.

When the mode bit is clear, the three control pins are plain general-purpose I/O. Each pin has its own data latch and direction latch, and the CPU reads back the pin levels. The CPU reaches everything through a simple register bus with address, write enable and read enable. Read data appears one cycle after the read enable.

Register map:
- Status register at 0x89. Bit 7 is inbound-full, bit 6 is outbound-full, bit 5 is overrun, bit 4 is mode, bit 3 always reads 0, and bits 2:0 are the directions of the select, write-strobe and read-strobe pins.
- Data register at 0x08. A read returns the inbound byte; a write loads the outbound byte.
- GPIO register at 0x09. A write sets the pin data latches in bits 2:0; a read returns the pin levels in bits 2:0, with the upper bits 0.

Top module: `pslv_port`

## Requirements
- R1: After reset the status register reads 0x07, and bus_oe and pin_oe[2:0] are all 0.
- R2: With mode at 1, a host write is select and write strobe both low, followed by a rise of the write strobe while select is still low. It captures bus_in into the inbound register and sets status bit 7. A CPU read of 0x08 returns that byte and clears bit 7.
- R3: A host write that arrives while status bit 7 is still set sets status bit 5, and the newer byte replaces the unread one.
- R4: Status bit 5 stays set until the CPU writes the status register with bit 5 at 0. Writing 1 there leaves the bit unchanged. If a clear and a new overrun fall in the same cycle, the bit stays set.
- R5: A CPU write to 0x08 loads the outbound byte and sets status bit 6. CPU writes to the status register cannot change bits 7 or 6.
- R6: With mode at 1, while select and the read strobe are both low, bus_oe is 1 and bus_out carries the outbound byte. When the read strobe returns high, bus_oe goes back to 0 and status bit 6 clears.
- R7: With mode at 0, host strobes have no effect: status bit 7 stays 0 and bus_oe stays 0.
- R8: With mode at 0, pin i is driven from GPIO latch bit i (pin_oe[i]=1) when direction bit i is 0, and is released when direction bit i is 1. A read of 0x09 returns the pin_in levels in bits 2:0 and 0 above.
- R9: With mode at 1, pin_oe[2:0] is 0 whatever the direction bits hold.
- R10: Status bit 3 reads as 0 even after a CPU write of 1 to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 8 | Register bus address |
| cpu_wr | input | 1 | Register write enable |
| cpu_rd | input | 1 | Register read enable |
| cpu_wdata | input | 8 | Register write data |
| cpu_rdata | output | 8 | Register read data, valid the cycle after cpu_rd |
| pin_in | input | 3 | Control pin levels: bit 2 select, bit 1 write strobe, bit 0 read strobe |
| pin_out | output | 3 | GPIO output values for the control pins |
| pin_oe | output | 3 | GPIO output enables for the control pins |
| bus_in | input | 8 | Host data bus input |
| bus_out | output | 8 | Host data bus output value |
| bus_oe | output | 1 | Host data bus output enable |

## Verification
The assertions assume that the host keeps select low for the whole of each strobe. They also assume that it never asserts both strobes together and that it holds bus_in steady until several cycles after the write strobe rises. The directed tasks follow these rules: select falls before a strobe and rises only after the strobe has been high for several cycles, and bus_in changes only between transactions. The CPU side issues one register access at a time and does not overlap it with a strobe edge, except in the same-cycle clear-and-overrun case, which the properties cover.

// File: rtl/pslv_pkg.sv
package pslv_pkg;
  localparam int PIN_CS = 2;
  localparam int PIN_WR = 1;
  localparam int PIN_RD = 0;
  localparam int NPINS  = 3;

  localparam int ST_IBF  = 7;
  localparam int ST_OBF  = 6;
  localparam int ST_IBOV = 5;
  localparam int ST_MODE = 4;

  function automatic logic [7:0] pack_status(input logic ibf, input logic obf,
                                             input logic ibov, input logic mode,
                                             input logic [NPINS-1:0] dir);
    return {ibf, obf, ibov, mode, 1'b0, dir};
  endfunction
endpackage

// File: rtl/pslv_sync.sv
module pslv_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q_out
);
  logic [W-1:0] stg [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= {W{RST_VAL}};
        else if (g == 0) stg[g] <= d_in;
        else stg[g] <= stg[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q_out = stg[STAGES-1];
endmodule

// File: rtl/pslv_flags.sv
module pslv_flags (
  input  logic clk,
  input  logic rst,
  input  logic wr_ev,
  input  logic rd_end,
  input  logic in_read,
  input  logic out_write,
  input  logic stat_write,
  input  logic stat_ibov_bit,
  output logic ibf,
  output logic obf,
  output logic ibov
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ibf  <= 1'b0;
      obf  <= 1'b0;
      ibov <= 1'b0;
    end else begin
      if (wr_ev) ibf <= 1'b1;
      else if (in_read) ibf <= 1'b0;

      if (out_write) obf <= 1'b1;
      else if (rd_end) obf <= 1'b0;

      if (wr_ev && ibf) ibov <= 1'b1;
      else if (stat_write && !stat_ibov_bit) ibov <= 1'b0;
    end
  end
endmodule

// File: rtl/pslv_port.sv
module pslv_port #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] A_STAT = 8'h89,
  parameter logic [ADDR_W-1:0] A_DATA = 8'h08,
  parameter logic [ADDR_W-1:0] A_GPIO = 8'h09
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic [2:0]        pin_in,
  output logic [2:0]        pin_out,
  output logic [2:0]        pin_oe,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe
);
  import pslv_pkg::*;

  logic [NPINS-1:0]  pin_s;
  logic [NPINS-1:0]  dir;
  logic [NPINS-1:0]  gpio_lat;
  logic              mode;
  logic [DATA_W-1:0] in_buf, out_buf;
  logic              wr_act, rd_act, wr_act_d, rd_act_d;
  logic              wr_ev, rd_end;
  logic              ibf, obf, ibov;
  logic              stat_write, out_write, in_read, gpio_write;

  pslv_sync #(.W(NPINS), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d_in(pin_in), .q_out(pin_s)
  );

  assign wr_act = mode & ~pin_s[PIN_CS] & ~pin_s[PIN_WR];
  assign rd_act = mode & ~pin_s[PIN_CS] & ~pin_s[PIN_RD];
  assign wr_ev  = mode & wr_act_d & ~wr_act;
  assign rd_end = mode & rd_act_d & ~rd_act;

  assign stat_write = cpu_wr && (cpu_addr == A_STAT);
  assign out_write  = cpu_wr && (cpu_addr == A_DATA);
  assign gpio_write = cpu_wr && (cpu_addr == A_GPIO);
  assign in_read    = cpu_rd && (cpu_addr == A_DATA);

  pslv_flags u_flags (
    .clk(clk), .rst(rst), .wr_ev(wr_ev), .rd_end(rd_end),
    .in_read(in_read), .out_write(out_write), .stat_write(stat_write),
    .stat_ibov_bit(cpu_wdata[ST_IBOV]),
    .ibf(ibf), .obf(obf), .ibov(ibov)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_act_d <= 1'b0;
      rd_act_d <= 1'b0;
      mode     <= 1'b0;
      dir      <= '1;
      gpio_lat <= '0;
      in_buf   <= '0;
      out_buf  <= '0;
    end else begin
      wr_act_d <= wr_act;
      rd_act_d <= rd_act;
      if (stat_write) begin
        mode <= cpu_wdata[ST_MODE];
        dir  <= cpu_wdata[NPINS-1:0];
      end
      if (gpio_write) gpio_lat <= cpu_wdata[NPINS-1:0];
      if (wr_ev) in_buf <= bus_in;
      if (out_write) out_buf <= cpu_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_rdata <= '0;
      pin_out   <= '0;
      pin_oe    <= '0;
      bus_out   <= '0;
      bus_oe    <= 1'b0;
    end else begin
      pin_out <= gpio_lat;
      pin_oe  <= mode ? '0 : ~dir;
      bus_out <= out_buf;
      bus_oe  <= rd_act;
      if (cpu_rd) begin
        if (cpu_addr == A_STAT)      cpu_rdata <= pack_status(ibf, obf, ibov, mode, dir);
        else if (cpu_addr == A_DATA) cpu_rdata <= in_buf;
        else if (cpu_addr == A_GPIO) cpu_rdata <= {{(DATA_W-NPINS){1'b0}}, pin_s};
        else                         cpu_rdata <= '0;
      end
    end
  end
endmodule

// File: rtl/pslv_port_chk.sv
module pslv_port_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] A_STAT = 8'h89,
  parameter logic [ADDR_W-1:0] A_DATA = 8'h08
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_wr,
  input logic              cpu_rd,
  input logic [DATA_W-1:0] cpu_wdata,
  input logic [DATA_W-1:0] cpu_rdata,
  input logic [2:0]        pin_oe,
  input logic              wr_ev,
  input logic              rd_end,
  input logic              ibf,
  input logic              obf,
  input logic              ibov,
  input logic              mode
);
  p_ibf_set_r2: assert property (@(posedge clk) disable iff (rst)
    wr_ev |=> ibf);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_ev && ibf) |=> ibov);

  p_ibov_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    (ibov && !(cpu_wr && cpu_addr == A_STAT && !cpu_wdata[5])) |=> ibov);

  p_obf_set_r5: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && cpu_addr == A_DATA) |=> obf);

  p_obf_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_end && !(cpu_wr && cpu_addr == A_DATA)) |=> !obf);

  p_strobe_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !mode |-> (!wr_ev && !rd_end));

  p_pins_released_r9: assert property (@(posedge clk) disable iff (rst)
    (mode && $stable(mode)) |=> (pin_oe == 3'b000));

  p_bit3_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && cpu_addr == A_STAT) |=> !cpu_rdata[3]);
endmodule

bind pslv_port pslv_port_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .A_STAT(A_STAT), .A_DATA(A_DATA)
) u_chk (
  .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
  .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .pin_oe(pin_oe),
  .wr_ev(wr_ev), .rd_end(rd_end), .ibf(ibf), .obf(obf), .ibov(ibov), .mode(mode)
);

// File: tb/sim_pslv_port.sv
module sim_pslv_port;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] cpu_addr = '0;
  logic       cpu_wr = 1'b0;
  logic       cpu_rd = 1'b0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata;
  logic [2:0] pin_in = 3'b111;
  logic [2:0] pin_out, pin_oe;
  logic [7:0] bus_in = '0;
  logic [7:0] bus_out;
  logic       bus_oe;

  int n_chk = 0;
  int n_bad = 0;

  localparam logic [7:0] STAT = 8'h89;
  localparam logic [7:0] DATA = 8'h08;
  localparam logic [7:0] GPIO = 8'h09;

  always #5 clk = ~clk;

  pslv_port u0 (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .bus_in(bus_in), .bus_out(bus_out),
    .bus_oe(bus_oe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cpu_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic cpu_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1'b1;
    @(negedge clk);
    cpu_rd = 1'b0;
    d = cpu_rdata;
  endtask

  task automatic host_write(input logic [7:0] d);
    @(negedge clk);
    bus_in = d; pin_in[2] = 1'b0;
    idle(2); pin_in[1] = 1'b0;
    idle(4); pin_in[1] = 1'b1;
    idle(4); pin_in[2] = 1'b1;
    idle(4);
  endtask

  task automatic host_read(output logic oe_mid, output logic [7:0] val_mid);
    @(negedge clk);
    pin_in[2] = 1'b0;
    idle(2); pin_in[0] = 1'b0;
    idle(5); oe_mid = bus_oe; val_mid = bus_out;
    pin_in[0] = 1'b1;
    idle(5); pin_in[2] = 1'b1;
    idle(3);
  endtask

  task automatic t_reset();
    logic [7:0] r;
    cpu_read(STAT, r);
    check("R1 status", r, 8'h07);
    check("R1 bus_oe", {7'b0, bus_oe}, 8'h00);
    check("R1 pin_oe", {5'b0, pin_oe}, 8'h00);
  endtask

  task automatic t_mode_off();
    logic [7:0] r, v; logic oe;
    host_write(8'h5A);
    cpu_read(STAT, r);
    check("R7 ibf stays 0", {7'b0, r[7]}, 8'h00);
    cpu_write(DATA, 8'h66);
    host_read(oe, v);
    check("R7 bus_oe stays 0", {7'b0, oe}, 8'h00);
    cpu_read(STAT, r);
    check("R7 obf kept", {7'b0, r[6]}, 8'h01);
    cpu_write(STAT, 8'h17);
    host_read(oe, v);
  endtask

  task automatic t_host_write();
    logic [7:0] r;
    host_write(8'hA5);
    cpu_read(STAT, r);
    check("R2 ibf set", r, 8'h97);
    cpu_read(DATA, r);
    check("R2 data", r, 8'hA5);
    cpu_read(STAT, r);
    check("R2 ibf cleared", {7'b0, r[7]}, 8'h00);
  endtask

  task automatic t_overflow();
    logic [7:0] r;
    host_write(8'h11);
    host_write(8'h22);
    cpu_read(STAT, r);
    check("R3 ibov set", {7'b0, r[5]}, 8'h01);
    cpu_read(DATA, r);
    check("R3 newer word", r, 8'h22);
    cpu_write(STAT, 8'h37);
    cpu_read(STAT, r);
    check("R4 write 1 keeps ibov", {7'b0, r[5]}, 8'h01);
    cpu_write(STAT, 8'h17);
    cpu_read(STAT, r);
    check("R4 write 0 clears ibov", r, 8'h17);
  endtask

  task automatic t_output();
    logic [7:0] r, v; logic oe;
    cpu_write(STAT, 8'hD7);
    cpu_read(STAT, r);
    check("R5 bits 7,6 read-only", r, 8'h17);
    cpu_write(DATA, 8'h3C);
    cpu_read(STAT, r);
    check("R5 obf set", {7'b0, r[6]}, 8'h01);
    host_read(oe, v);
    check("R6 bus_oe during read", {7'b0, oe}, 8'h01);
    check("R6 bus_out value", v, 8'h3C);
    check("R6 bus_oe after read", {7'b0, bus_oe}, 8'h00);
    cpu_read(STAT, r);
    check("R6 obf cleared", {7'b0, r[6]}, 8'h00);
  endtask

  task automatic t_bit3();
    logic [7:0] r;
    cpu_write(STAT, 8'h1F);
    cpu_read(STAT, r);
    check("R10 bit3 reads 0", r, 8'h17);
  endtask

  task automatic t_mode_pins();
    cpu_write(STAT, 8'h10);
    idle(3);
    check("R9 pins released", {5'b0, pin_oe}, 8'h00);
  endtask

  task automatic t_gpio();
    logic [7:0] r;
    cpu_write(STAT, 8'h02);
    cpu_write(GPIO, 8'h05);
    idle(3);
    check("R8 pin_oe", {5'b0, pin_oe}, 8'h05);
    check("R8 pin_out", {5'b0, pin_out}, 8'h05);
    pin_in = 3'b011;
    idle(4);
    cpu_read(GPIO, r);
    check("R8 pin levels", r, 8'h03);
    pin_in = 3'b111;
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    idle(2);
    t_reset();
    t_mode_off();
    t_host_write();
    t_overflow();
    t_output();
    t_bit3();
    t_mode_pins();
    t_gpio();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule